// File: doc/BRIEF.md
# Dual H-Bridge Gate Driver with Programmable Dead Time

This block takes the one-bit outputs of two audio modulators, one for the left channel and one for the right. It turns them into gate-drive signals for two H-bridges. Each H-bridge has two legs, and each leg has a high-side gate and a low-side gate, so there are eight gates in all. The positive leg of a bridge follows the channel bit. The negative leg follows the inverted bit, so the voltage across the load is differential.

The two gates of a leg are never on together. When a leg's demand changes, the gate that is on turns off first. Both gates then stay off for a programmable number of clock cycles before the opposite gate turns on. A mono mode routes the left channel bit to both bridges so that they can share one load current. A drive enable switches every gate off at once.

The block runs on the modulator clock, which is 256 times the sample rate.

Top module: `hbd_top`

## Requirements
- R1: While `rst_n` is low, all eight gate outputs are 0.
- R2: On every leg, the high-side gate and the low-side gate are never both 1.
- R3: Both gates of a leg stay off for exactly `gap_sel + 1` clock cycles between one gate turning off and the other turning on. With `gap_sel` = 0 the gap is one cycle, and with 7 it is eight cycles.
- R4: When a leg's demand changes, the gate that was on goes low at the first rising clock edge that samples the new demand.
- R5: If the demand changes again during a gap, the gap restarts from zero in the new direction. A full `gap_sel + 1` cycle gap then precedes the turn-on.
- R6: Leg order is index 0 = left positive, 1 = left negative, 2 = right positive, 3 = right negative. A positive leg drives its high gate when its channel bit is 1. A negative leg drives its high gate when the bit is 0. The two high gates of one bridge are never on together, and neither are its two low gates.
- R7: When `mono_sel` is 1, both bridges follow `mod_bit[0]` (left), and `mod_bit[1]` has no effect on any gate.
- R8: When `drive_en` is 0, all eight gates are 0 in the same cycle, without waiting for a clock edge.
- R9: After `drive_en` returns to 1, every leg keeps both gates off for `gap_sel + 1` cycles and then drives the gate its demand selects.
- R10: When `mono_sel` is 0, the right bridge follows `mod_bit[1]`, independently of `mod_bit[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock (256 x sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| drive_en | input | 1 | 1 = drive gates, 0 = all gates off at once |
| mono_sel | input | 1 | 1 = left bit drives both bridges |
| mod_bit | input | 2 | Modulator bits, [0] left, [1] right |
| gap_sel | input | GAP_W (3) | Dead-time setting, gap = setting + 1 cycles |
| gate_hi | output | 4 | High-side gates, index per R6 |
| gate_lo | output | 4 | Low-side gates, index per R6 |

## Verification
The bench builds the block with the default 3-bit dead-time setting. This brings every setting from 0 to 7 within reach, and the bench times the shortest gap, a middle gap and the longest gap cycle by cycle. With that width, a re-toggle inside a four-cycle gap can be placed and the restart of the gap observed. Re-enable is timed against the same setting.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int NUM_CH   = 2;
  localparam int LEGS_PER = 2;
  localparam int NUM_LEG  = NUM_CH * LEGS_PER;

  typedef enum logic [1:0] {
    LEG_GAP = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_state_e;
endpackage

// File: rtl/hbd_rst_sync.sv
module hbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/hbd_steer.sv
module hbd_steer
  import hbd_pkg::*;
(
  input  logic              mono_sel,
  input  logic [NUM_CH-1:0] mod_bit,
  output logic [NUM_LEG-1:0] leg_dem
);
  logic [NUM_CH-1:0] ch_bit;

  always_comb begin
    ch_bit[0] = mod_bit[0];
    ch_bit[1] = mono_sel ? mod_bit[0] : mod_bit[1];
  end

  // positive leg takes the bit, negative leg its complement
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign leg_dem[c*LEGS_PER]     =  ch_bit[c];
    assign leg_dem[c*LEGS_PER + 1] = ~ch_bit[c];
  end
endmodule

// File: rtl/hbd_leg.sv
module hbd_leg
  import hbd_pkg::*;
#(
  parameter int GAP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drive_en,
  input  logic             dem,
  input  logic [GAP_W-1:0] gap_sel,
  output logic             gate_hi,
  output logic             gate_lo
);
  leg_state_e       state_q, state_d;
  logic             tgt_q, tgt_d;
  logic             arm_q, arm_d;
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             cnt_clr, cnt_inc;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    arm_d   = arm_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (!drive_en) begin
      state_d = LEG_GAP;
      arm_d   = 1'b1;
      tgt_d   = dem;
      cnt_clr = 1'b1;
    end else begin
      unique case (state_q)
        LEG_HI: if (!dem) begin
          state_d = LEG_GAP;
          tgt_d   = 1'b0;
          cnt_clr = 1'b1;
        end
        LEG_LO: if (dem) begin
          state_d = LEG_GAP;
          tgt_d   = 1'b1;
          cnt_clr = 1'b1;
        end
        default: begin
          if (arm_q || (dem != tgt_q)) begin
            arm_d   = 1'b0;
            tgt_d   = dem;
            cnt_clr = 1'b1;
          end else if (cnt_q >= gap_sel) begin
            state_d = tgt_q ? LEG_HI : LEG_LO;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_clr)      cnt_d = '0;
    else if (cnt_inc) cnt_d = cnt_q + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LEG_GAP;
      tgt_q   <= 1'b0;
      arm_q   <= 1'b1;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      arm_q   <= arm_d;
      if (cnt_clr || cnt_inc) cnt_q <= cnt_d;
    end
  end

  assign gate_hi = drive_en && (state_q == LEG_HI);
  assign gate_lo = drive_en && (state_q == LEG_LO);
endmodule

// File: rtl/hbd_top.sv
module hbd_top
  import hbd_pkg::*;
#(
  parameter int GAP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_en,
  input  logic              mono_sel,
  input  logic [1:0]        mod_bit,
  input  logic [GAP_W-1:0]  gap_sel,
  output logic [3:0]        gate_hi,
  output logic [3:0]        gate_lo
);
  logic               rst_n_int;
  logic [NUM_LEG-1:0] leg_dem;

  hbd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  hbd_steer u_steer (
    .mono_sel (mono_sel),
    .mod_bit  (mod_bit),
    .leg_dem  (leg_dem)
  );

  for (genvar g = 0; g < NUM_LEG; g++) begin : g_leg
    hbd_leg #(.GAP_W(GAP_W)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .drive_en (drive_en),
      .dem      (leg_dem[g]),
      .gap_sel  (gap_sel),
      .gate_hi  (gate_hi[g]),
      .gate_lo  (gate_lo[g])
    );
  end
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       drive_en,
  input logic [3:0] gate_hi,
  input logic [3:0] gate_lo
);
  always_comb begin
    if (!rst_n) AST_RESET_OFF: assert ({gate_hi, gate_lo} == 8'h00); // R1
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == 4'h0); // R2

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> ({gate_hi, gate_lo} == 8'h00)); // R8

  AST_BRIDGE_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi[0] & gate_hi[1]) | (gate_hi[2] & gate_hi[3]) |
     (gate_lo[0] & gate_lo[1]) | (gate_lo[2] & gate_lo[3])) == 1'b0); // R6

  for (genvar g = 0; g < 4; g++) begin : g_leg
    AST_HI_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[g]) |-> !$past(gate_lo[g])); // R3
    AST_LO_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[g]) |-> !$past(gate_hi[g])); // R3
  end
endmodule

bind hbd_top hbd_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .drive_en (drive_en),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo)
);

// File: tb/hbd_top_bench.sv
`timescale 1ns/1ps
module hbd_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       drive_en;
  logic       mono_sel;
  logic [1:0] mod_bit;
  logic [2:0] gap_sel;
  logic [3:0] gate_hi, gate_lo;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  hbd_top u_hbd_top (
    .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .mono_sel(mono_sel),
    .mod_bit(mod_bit), .gap_sel(gap_sel), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // expected {hi,lo} in steady state, leg order per R6
  function automatic logic [7:0] steady(input logic l, input logic r, input logic mono);
    logic rb;
    logic [3:0] hi;
    rb = mono ? l : r;
    hi = {~rb, rb, ~l, l};
    return {hi, ~hi};
  endfunction

  task automatic chk(input string req, input logic [7:0] exp);
    total++;
    if ({gate_hi, gate_lo} !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, {gate_hi, gate_lo}, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; drive_en = 1'b1; mono_sel = 1'b0; mod_bit = 2'b01; gap_sel = 3'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset", 8'h00);
    rst_n = 1'b1;
    settle();
    chk("R6 after reset", steady(1'b1, 1'b0, 1'b0));
  endtask

  task automatic t_stereo();
    mono_sel = 1'b0;
    for (int p = 0; p < 4; p++) begin
      mod_bit = p[1:0];
      settle();
      chk("R6/R10 stereo steady", steady(mod_bit[0], mod_bit[1], 1'b0));
    end
  endtask

  // left bit flips; left legs off for sel+1 samples, right bridge untouched
  task automatic t_gap(input logic [2:0] sel);
    logic [7:0] mid;
    gap_sel = sel; mono_sel = 1'b0; mod_bit = 2'b01;
    settle();
    mod_bit = 2'b00;
    mid = steady(1'b0, 1'b0, 1'b0) & 8'b1100_1100;
    for (int k = 0; k <= int'(sel); k++) begin
      @(negedge clk);
      chk(k == 0 ? "R4 on-gate drops at first edge" : "R3 gap off", mid);
    end
    @(negedge clk);
    chk("R3 gap end", steady(1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_retoggle();
    logic [7:0] mid;
    gap_sel = 3'd3; mono_sel = 1'b0; mod_bit = 2'b11;
    settle();
    mod_bit = 2'b10;
    mid = steady(1'b0, 1'b1, 1'b0) & 8'b1100_1100;
    @(negedge clk); chk("R5 first gap sample", mid);
    @(negedge clk); chk("R5 second gap sample", mid);
    mod_bit = 2'b11;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R5 restarted gap off", mid);
    end
    @(negedge clk);
    chk("R5 restarted gap end", steady(1'b1, 1'b1, 1'b0));
  endtask

  task automatic t_mono();
    gap_sel = 3'd1; mono_sel = 1'b1; mod_bit = 2'b01;
    settle();
    chk("R7 mono follows left", steady(1'b1, 1'b1, 1'b0));
    mod_bit = 2'b11;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 right bit ignored", steady(1'b1, 1'b1, 1'b0));
    end
    mod_bit = 2'b10;
    settle();
    chk("R7 mono left=0", steady(1'b0, 1'b0, 1'b0));
    mono_sel = 1'b0;
    settle();
    chk("R10 back to stereo", steady(1'b0, 1'b1, 1'b0));
  endtask

  task automatic t_enable();
    gap_sel = 3'd2; mono_sel = 1'b0; mod_bit = 2'b01;
    settle();
    drive_en = 1'b0;
    #1 chk("R8 off without clock edge", 8'h00);
    repeat (3) @(negedge clk);
    chk("R8 held off", 8'h00);
    drive_en = 1'b1;
    #1 chk("R9 still off at enable", 8'h00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 re-enable gap", 8'h00);
    end
    @(negedge clk);
    chk("R9 drive after gap", steady(1'b1, 1'b0, 1'b0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_stereo();
    t_gap(3'd0);
    t_gap(3'd3);
    t_gap(3'd7);
    t_retoggle();
    t_mono();
    t_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule